// File: doc/BRIEF.md
# Disk Controller Command Phase Sequencer

This block is the host-facing front end of a diskette controller. The host talks to it through one byte-wide data port and reads a status byte that reports the handshake state. The host writes the first command byte. The block decodes its low five bits to learn how many more bytes make up the command, and it collects them. It then gives the whole command to an execution engine as a one-cycle strobe, together with the captured bytes and their count.

When the engine finishes, it returns a block of result bytes. The sequencer turns the port around and hands those bytes to the host one read at a time, lowest byte first. After the last read it goes back to idle. Some opcodes return nothing, and their completion goes straight to idle. An opcode the decoder does not recognise, and the version query, never reach the engine: the block answers each of them itself with one fixed byte.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the status byte `msr_o` reads 80h ORed with `seek_busy_i`. In that byte, bit 7 is ready, bit 6 is direction (1 = block to host), bit 5 is non-DMA execution, bit 4 is busy, and bits 3..0 copy `seek_busy_i`. `rdata_o` reads 0 outside the result phase.
- R2: The command length comes from bits 4..0 of the first byte, and bits 7..5 have no effect on it. Codes 00110, 01100, 00101, 01001, 00010, 10001, 11001 and 11101 take 9 bytes. 01010 takes 2 bytes, 01101 takes 6, 00111 takes 2, 01000 takes 1, 00011 takes 3, 00100 takes 2 and 01111 takes 3. `cmd_len_o` gives that count when the command is handed over.
- R3: `cmd_valid_o` is high for exactly one cycle, in the cycle after the edge that accepts the final command byte. `cmd_bytes_o[8k+7:8k]` holds command byte k, and bytes at or beyond the command length read 0.
- R4: During execution, `msr_o` shows ready 0, busy 1 and direction 0. It stays that way until `exec_done_i` is sampled high.
- R5: When the engine completes, the block enters the result phase with ready 1, direction 1 and busy 1. Each read returns `res_bytes_i[8k+7:8k]` as captured on that completion, with k counting from 0. Codes 00110, 01100, 00101, 01001, 00010, 10001, 11001, 11101, 01010 and 01101 return 7 bytes, 01000 returns 2 and 00100 returns 1. Codes 00111, 00011 and 01111 go idle on completion with no result phase.
- R6: A one-byte command whose bits 4..0 match no listed code gives no `cmd_valid_o`. It enters the result phase at once with the single byte 80h, which means invalid command (bits 7:6 = 10).
- R7: Code 10000 gives no `cmd_valid_o` and returns the single byte 90h.
- R8: When the last result byte has been read, `msr_o` returns to 80h ORed with `seek_busy_i`.
- R9: A write in the execution or result phase is ignored, and so is a read in the idle or command phase. Neither one advances a byte counter.
- R10: Bit 0 of the third byte of code 00011 sets a stored non-DMA flag. `msr_o` bit 5 shows that flag only during execution. The flag takes its new value from that command's own execution onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe on the data port |
| rd_i | input | 1 | Host read strobe on the data port |
| wdata_i | input | DW | Host write data |
| rdata_o | output | DW | Current result byte |
| seek_busy_i | input | DRIVES | Per-drive seek-busy flags from the engine |
| exec_done_i | input | 1 | Engine completion pulse |
| res_bytes_i | input | MAX_RES*DW | Result bytes, byte 0 lowest |
| msr_o | output | DRIVES+4 | Handshake status byte |
| cmd_valid_o | output | 1 | Command handover strobe |
| cmd_len_o | output | clog2(MAX_CMD+1) | Number of captured command bytes |
| cmd_bytes_o | output | MAX_CMD*DW | Captured command bytes, byte 0 lowest |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 9-byte command store, a 7-byte result store and four drive flags. At these sizes the longest commands fill the command store to its last slot, and the full seven-byte results drain through the last result index. That makes the counter terminal values and the zero fill of unused command slots observable. The four drive flags make the pass-through of the low status bits visible with two different patterns.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} phase_e;
  localparam int OP_W = 5;
  localparam logic [7:0] ST0_BAD_OP = 8'h80;
  localparam logic [7:0] ID_BYTE    = 8'h90;
endpackage

// File: rtl/fdc_op_decode.sv
module fdc_op_decode #(
  parameter int CW = 4,
  parameter int RW = 3
) (
  input  logic [fdc_seq_pkg::OP_W-1:0] op_i,
  output logic [CW-1:0]                n_cmd_o,
  output logic [RW-1:0]                n_res_o,
  output logic                         local_o,
  output logic [7:0]                   code_o,
  output logic                         nd_cfg_o
);
  always_comb begin
    local_o  = 1'b0;
    code_o   = 8'h00;
    nd_cfg_o = 1'b0;
    unique case (op_i)
      5'b00110, 5'b01100, 5'b00101, 5'b01001,
      5'b00010, 5'b10001, 5'b11001, 5'b11101: begin
        n_cmd_o = CW'(9); n_res_o = RW'(7);
      end
      5'b01010: begin n_cmd_o = CW'(2); n_res_o = RW'(7); end
      5'b01101: begin n_cmd_o = CW'(6); n_res_o = RW'(7); end
      5'b00111: begin n_cmd_o = CW'(2); n_res_o = RW'(0); end
      5'b01000: begin n_cmd_o = CW'(1); n_res_o = RW'(2); end
      5'b00011: begin n_cmd_o = CW'(3); n_res_o = RW'(0); nd_cfg_o = 1'b1; end
      5'b00100: begin n_cmd_o = CW'(2); n_res_o = RW'(1); end
      5'b01111: begin n_cmd_o = CW'(3); n_res_o = RW'(0); end
      5'b10000: begin
        n_cmd_o = CW'(1); n_res_o = RW'(1);
        local_o = 1'b1;   code_o  = fdc_seq_pkg::ID_BYTE;
      end
      default: begin
        n_cmd_o = CW'(1); n_res_o = RW'(1);
        local_o = 1'b1;   code_o  = fdc_seq_pkg::ST0_BAD_OP;
      end
    endcase
  end
endmodule

// File: rtl/fdc_cmd_store.sv
module fdc_cmd_store #(
  parameter int DW = 8,
  parameter int N  = 9,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] idx_i,
  input  logic [DW-1:0] d_i,
  output logic [N*DW-1:0] bytes_o
);
  for (genvar k = 0; k < N; k++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot_q <= '0;
      else if (we_i && idx_i == CW'(k))         slot_q <= d_i;
      else if (we_i && idx_i == '0)             slot_q <= '0;  // new command clears stale bytes
    end
    assign bytes_o[k*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/fdc_res_store.sv
module fdc_res_store #(
  parameter int DW = 8,
  parameter int N  = 7,
  parameter int RW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [N*DW-1:0] d_i,
  input  logic [RW-1:0]   sel_i,
  output logic [DW-1:0]   q_o
);
  logic [DW-1:0] mem_q [N];

  for (genvar k = 0; k < N; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mem_q[k] <= '0;
      else if (load_i) mem_q[k] <= d_i[k*DW +: DW];
    end
  end

  always_comb begin
    q_o = '0;
    for (int k = 0; k < N; k++)
      if (sel_i == RW'(k)) q_o = mem_q[k];
  end
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq #(
  parameter int DW      = 8,
  parameter int MAX_CMD = 9,
  parameter int MAX_RES = 7,
  parameter int DRIVES  = 4,
  localparam int CW = $clog2(MAX_CMD + 1),
  localparam int RW = $clog2(MAX_RES + 1),
  localparam int MW = DRIVES + 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic [DRIVES-1:0]     seek_busy_i,
  input  logic                  exec_done_i,
  input  logic [MAX_RES*DW-1:0] res_bytes_i,
  output logic [MW-1:0]         msr_o,
  output logic                  cmd_valid_o,
  output logic [CW-1:0]         cmd_len_o,
  output logic [MAX_CMD*DW-1:0] cmd_bytes_o
);
  import fdc_seq_pkg::*;

  phase_e        phase_q;
  logic [CW-1:0] idx_q, n_cmd_q, st_idx, cur_len;
  logic [RW-1:0] n_res_q, ridx_q;
  logic          valid_q, nd_q, nd_cfg_q;

  logic [CW-1:0] dec_n_cmd;
  logic [RW-1:0] dec_n_res;
  logic          dec_local, dec_nd_cfg;
  logic [7:0]    dec_code;

  logic wr_acc, rd_acc, last_wr, local_load, res_load;
  logic [MAX_RES*DW-1:0] res_d;
  logic [DW-1:0]         res_q;

  fdc_op_decode #(.CW(CW), .RW(RW)) u_dec (
    .op_i     (wdata_i[OP_W-1:0]),
    .n_cmd_o  (dec_n_cmd),
    .n_res_o  (dec_n_res),
    .local_o  (dec_local),
    .code_o   (dec_code),
    .nd_cfg_o (dec_nd_cfg)
  );

  assign wr_acc  = wr_i && (phase_q == PH_IDLE || phase_q == PH_CMD);
  assign rd_acc  = rd_i && (phase_q == PH_RES);
  assign st_idx  = (phase_q == PH_IDLE) ? '0 : idx_q;
  assign cur_len = (phase_q == PH_IDLE) ? dec_n_cmd : n_cmd_q;
  assign last_wr = wr_acc && (st_idx == cur_len - CW'(1));

  fdc_cmd_store #(.DW(DW), .N(MAX_CMD), .CW(CW)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_acc),
    .idx_i   (st_idx),
    .d_i     (wdata_i),
    .bytes_o (cmd_bytes_o)
  );

  assign local_load = wr_acc && (phase_q == PH_IDLE) && dec_local;
  assign res_load   = local_load || (phase_q == PH_EXEC && exec_done_i);
  assign res_d      = local_load ? {{(MAX_RES*DW-8){1'b0}}, dec_code} : res_bytes_i;

  fdc_res_store #(.DW(DW), .N(MAX_RES), .RW(RW)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (res_load),
    .d_i    (res_d),
    .sel_i  (ridx_q),
    .q_o    (res_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      idx_q    <= '0;
      n_cmd_q  <= '0;
      n_res_q  <= '0;
      ridx_q   <= '0;
      valid_q  <= 1'b0;
      nd_q     <= 1'b0;
      nd_cfg_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (wr_acc) begin
          n_cmd_q  <= dec_n_cmd;
          n_res_q  <= dec_n_res;
          nd_cfg_q <= dec_nd_cfg;
          ridx_q   <= '0;
          if (dec_local)   phase_q <= PH_RES;
          else if (last_wr) begin
            phase_q <= PH_EXEC;
            valid_q <= 1'b1;
          end else begin
            phase_q <= PH_CMD;
            idx_q   <= CW'(1);
          end
        end
        PH_CMD: if (wr_acc) begin
          if (last_wr) begin
            phase_q <= PH_EXEC;
            valid_q <= 1'b1;
            if (nd_cfg_q) nd_q <= wdata_i[0];
          end else begin
            idx_q <= idx_q + CW'(1);
          end
        end
        PH_EXEC: if (exec_done_i) begin
          ridx_q  <= '0;
          phase_q <= (n_res_q == '0) ? PH_IDLE : PH_RES;
        end
        PH_RES: if (rd_acc) begin
          if (ridx_q == n_res_q - RW'(1)) phase_q <= PH_IDLE;
          else                            ridx_q  <= ridx_q + RW'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = valid_q;
  assign cmd_len_o   = n_cmd_q;
  assign rdata_o     = (phase_q == PH_RES) ? res_q : '0;
  assign msr_o       = {phase_q != PH_EXEC,
                        phase_q == PH_RES,
                        nd_q && (phase_q == PH_EXEC),
                        phase_q != PH_IDLE,
                        seek_busy_i};
endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk #(
  parameter int DW = 8,
  parameter int MW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          rd_i,
  input logic          exec_done_i,
  input logic          cmd_valid_o,
  input logic [DW-1:0] rdata_o,
  input logic [MW-1:0] msr_o
);
  logic rdy, dir, nd, bsy;
  assign rdy = msr_o[MW-1];
  assign dir = msr_o[MW-2];
  assign nd  = msr_o[MW-3];
  assign bsy = msr_o[MW-4];

  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  p_valid_in_exec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (!rdy && bsy && !dir));

  p_exec_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy && !exec_done_i) |=> !rdy);

  p_res_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir |-> (rdy && bsy));

  p_idle_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bsy |-> (rdy && !dir));

  p_wr_in_res_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir && wr_i && !rd_i) |=> (dir && $stable(rdata_o)));

  p_rd_in_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy && !dir && rd_i && !wr_i) |=> !dir);

  p_nd_exec_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nd |-> !rdy);
endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk #(.DW(DW), .MW(DRIVES + 4)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .exec_done_i (exec_done_i),
  .cmd_valid_o (cmd_valid_o),
  .rdata_o     (rdata_o),
  .msr_o       (msr_o)
);

// File: tb/fdc_cmd_seq_test.sv
`timescale 1ns/1ps
module fdc_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, done = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  seek = 4'b0101;
  logic [55:0] res = '0;
  logic [7:0]  msr;
  logic        cvalid;
  logic [3:0]  clen;
  logic [71:0] cbytes;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  fdc_cmd_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .seek_busy_i(seek), .exec_done_i(done),
    .res_bytes_i(res), .msr_o(msr), .cmd_valid_o(cvalid),
    .cmd_len_o(clen), .cmd_bytes_o(cbytes)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_fail++;
      $display("FAIL watchdog (all R) actual=%0d expected<%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); wr = 1'b1; wdata = b;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] v);
    @(negedge clk); v = rdata; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic finish_exec(input logic [55:0] r);
    @(negedge clk); done = 1'b1; res = r;
    @(negedge clk); done = 1'b0;
  endtask

  // full command: write n bytes, complete, drain nres results
  task automatic run_cmd(input logic [71:0] b, input int n, input int nres, input string tag);
    logic [71:0] expb;
    logic [55:0] r;
    logic [7:0]  v;
    expb = '0;
    for (int i = 0; i < n; i++) begin
      wr_byte(b[8*i +: 8]);
      expb[8*i +: 8] = b[8*i +: 8];
      if (i < n - 1) begin
        chk({"R2 mid-command msr ", tag}, 72'(msr & 8'hDF), 72'h95);
        chk({"R3 no early strobe ", tag}, 72'(cvalid), 72'd0);
      end
    end
    chk({"R3 strobe ", tag}, 72'(cvalid), 72'd1);
    chk({"R2 length ", tag}, 72'(clen), 72'(n));
    chk({"R3 bytes ", tag}, cbytes, expb);
    chk({"R4 exec flags ", tag}, 72'({msr[7], msr[6], msr[4]}), 72'b001);
    @(negedge clk);
    chk({"R3 strobe width ", tag}, 72'(cvalid), 72'd0);
    chk({"R4 exec hold ", tag}, 72'(msr[7]), 72'd0);
    for (int k = 0; k < 7; k++) r[8*k +: 8] = 8'h30 + 8'(k) + 8'(n << 4);
    finish_exec(r);
    if (nres == 0) begin
      chk({"R5 no result phase ", tag}, 72'(msr), 72'h85);
    end else begin
      for (int k = 0; k < nres; k++) begin
        chk({"R5 result flags ", tag}, 72'(msr), 72'hD5);
        rd_byte(v);
        chk({"R5 result byte ", tag}, 72'(v), 72'(r[8*k +: 8]));
      end
      chk({"R8 back to idle ", tag}, 72'(msr), 72'h85);
      chk({"R1 rdata idle ", tag}, 72'(rdata), 72'h0);
    end
  endtask

  task automatic run_local(input logic [7:0] op, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    wr_byte(op);
    chk({tag, " no strobe"}, 72'(cvalid), 72'd0);
    chk({tag, " result flags"}, 72'(msr), 72'hD5);
    rd_byte(v);
    chk({tag, " code"}, 72'(v), 72'(exp));
    chk({"R8 idle after ", tag}, 72'(msr), 72'h85);
  endtask

  task automatic t_reset;
    chk("R1 reset msr", 72'(msr), 72'h85);
    chk("R1 reset rdata", 72'(rdata), 72'h0);
    chk("R3 reset strobe", 72'(cvalid), 72'd0);
    @(negedge clk); seek = 4'b1010;
    @(negedge clk); chk("R1 seek flags", 72'(msr), 72'h8A);
    seek = 4'b0101;
    @(negedge clk);
  endtask

  task automatic t_lengths;
    run_cmd(72'h08_2A_12_02_05_01_00_02_46, 9, 7, "R2 read data");
    run_cmd(72'h11_1B_12_02_07_00_03_01_C9, 9, 7, "R2 write deleted with flags");
    run_cmd(72'h01_1B_12_02_01_00_00_00_7D, 9, 7, "R2 scan high");
    run_cmd(72'h0000_0000_0000_0000_4A,     2, 7, "R2 read id");
    run_cmd(72'h0000_00F6_1B12_0200_4D,     6, 7, "R2 format");
    run_cmd(72'h08,                         1, 2, "R2 sense interrupt");
    run_cmd(72'h0001_04,                    2, 1, "R2 sense drive");
    run_cmd(72'h2800_0F,                    3, 0, "R2 seek");
    run_cmd(72'h0000_07,                    2, 0, "R2 recalibrate");
  endtask

  task automatic t_local;
    run_local(8'h1F, 8'h80, "R6 unknown 11111");
    run_local(8'h00, 8'h80, "R6 unknown 00000");
    run_local(8'h10, 8'h90, "R7 version");
    run_local(8'hF0, 8'h90, "R7 version with flags");
  endtask

  task automatic t_ignore;
    logic [7:0] v;
    wr_byte(8'h0F);
    rd_byte(v);
    chk("R9 read in command phase", 72'(msr), 72'h95);
    wr_byte(8'h01);
    wr_byte(8'h05);
    chk("R9 count not advanced by read", 72'(cvalid), 72'd1);
    chk("R9 bytes after ignored read", cbytes, 72'h05_01_0F);
    wr_byte(8'hEE);
    chk("R9 write in exec", 72'(msr), 72'h15);
    chk("R9 exec write no store", cbytes, 72'h05_01_0F);
    finish_exec('0);
    chk("R9 seek done", 72'(msr), 72'h85);
    wr_byte(8'h08);
    finish_exec(56'h22_11);
    wr_byte(8'h77);
    chk("R9 write in result keeps byte", 72'(rdata), 72'h11);
    chk("R9 write in result keeps phase", 72'(msr), 72'hD5);
    rd_byte(v); chk("R9 first result", 72'(v), 72'h11);
    rd_byte(v); chk("R9 second result", 72'(v), 72'h22);
    chk("R9 idle", 72'(msr), 72'h85);
  endtask

  task automatic t_nondma;
    wr_byte(8'h03); wr_byte(8'hAF); wr_byte(8'h01);
    chk("R10 set during own exec", 72'(msr), 72'h35);
    finish_exec('0);
    chk("R10 hidden in idle", 72'(msr), 72'h85);
    wr_byte(8'h07); wr_byte(8'h00);
    chk("R10 shown in later exec", 72'(msr[5]), 72'd1);
    finish_exec('0);
    wr_byte(8'h03); wr_byte(8'hAF); wr_byte(8'h00);
    chk("R10 cleared", 72'(msr), 72'h15);
    finish_exec('0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_local();
    t_ignore();
    t_nondma();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule